// File: doc/BRIEF.md
# Serial Engine Command Stream Parser

This block sits between a host byte channel and the engines of a synchronous serial controller. It takes a stream of opcode and parameter bytes on a valid/ready byte interface and classifies each opcode. Opcodes with bit 7 clear are shift commands; opcodes with bit 7 set are control commands. From that class and from the opcode's own bits it works out how many parameter bytes follow. Once it has collected them, it presents one decoded record holding the opcode, a length or generic parameter value, a GPIO value and direction pair, an address and a data byte.

A byte-mode shift that writes data also carries a variable-length payload. Its size comes from the little-endian length field. After the record has been taken, the payload bytes pass straight from the input to a payload port, so the shifter receives them without intermediate storage. An unknown opcode raises a single-cycle flag. The byte is then dropped, and the next byte is parsed as a fresh opcode.

The record fields are cleared to zero when a new opcode is taken. Fields that a given opcode does not use therefore read as zero.

Top module: `cmdstream_parser`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), in_ready is 1 and rec_valid, pay_valid and bad_cmd are 0.
- R2: The parameterless control opcodes produce a record in the cycle after the opcode is accepted, with rec_length, rec_gpio_value, rec_gpio_dir, rec_addr and rec_data all zero. These opcodes are 0x81, 0x83, 0x84, 0x85, 0x87, 0x88, 0x89, 0x8A to 0x8D, and 0x94 to 0x97.
- R3: A shift opcode with bit 1 clear (byte mode) takes two length bytes, low byte first. rec_length is that raw 16-bit value, which is the transfer count minus one.
- R4: For a byte-mode shift with bit 4 set (data write), the record is accepted first. Then exactly rec_length+1 further input bytes appear unchanged on pay_data with pay_valid, no record is produced for them, and the byte after them is parsed as an opcode. No other opcode produces payload.
- R5: A shift opcode with bit 1 set (bit mode) takes one length byte, which goes to rec_length[7:0] with the upper bits zero. If bit 4 or bit 6 is set, one more byte follows and goes to rec_data; otherwise rec_data is 0.
- R6: Opcodes 0x80 and 0x82 take two bytes: the first goes to rec_gpio_value and the second to rec_gpio_dir.
- R7: For the CPU-mode opcodes, the address and data are placed as follows.
  - 0x90: one address byte, giving rec_addr = {0x00, byte}.
  - 0x91: two address bytes, high byte first.
  - 0x92: a one-byte address and then a data byte, which goes to rec_data.
  - 0x93: a two-byte address (high byte first) and then a data byte, which goes to rec_data.
- R8: Opcodes 0x86, 0x8F, 0x9C, 0x9D and 0x9E take two bytes, placed low byte first into rec_length. Opcode 0x8E takes one byte, which goes to rec_length[7:0].
- R9: An unknown opcode makes bad_cmd 1 for exactly the one cycle after acceptance. It produces no record, and the next byte is parsed as an opcode. The known shift opcodes are defined by their write bit (b4), read bit (b5) and mode-select bit (b6); any other b6/b5/b4 combination is unknown:
  - b6/b5/b4 = 001: known when b2 = 0.
  - 010: known when b0 = 0.
  - 011: known when b0 differs from b2.
  - 100: known when b3 = 1, b1 = 1 and b2 = 0.
  - 110: known when b3 = 1 and b1 = 1.
  - The known control opcodes are 0x80 to 0x97 and 0x9C to 0x9E.
- R10: While rec_valid is 1 and rec_ready is 0, in_ready is 0 and every record output holds its value.
- R11: During payload transfer, in_ready equals pay_ready, so a byte is consumed only when the payload consumer takes it.
- R12: A reset in the middle of a command discards the partial command, and the next byte is parsed as an opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Parser takes the input byte this cycle |
| rec_valid | output | 1 | Decoded record available |
| rec_ready | input | 1 | Consumer takes the record |
| rec_opcode | output | 8 | Opcode of the record |
| rec_length | output | 16 | Length field or generic two-byte parameter |
| rec_gpio_value | output | 8 | GPIO output value |
| rec_gpio_dir | output | 8 | GPIO direction mask |
| rec_addr | output | 16 | CPU-mode address |
| rec_data | output | 8 | CPU-mode data or bit-mode data byte |
| pay_valid | output | 1 | Payload byte valid |
| pay_ready | input | 1 | Payload consumer takes the byte |
| pay_data | output | 8 | Payload byte |
| bad_cmd | output | 1 | One-cycle flag for an unknown opcode |

## Verification
The assertions assume that the record consumer and the payload consumer are driven only from their ready inputs. They also assume that the input side holds a byte steady until in_ready takes it. The stimulus changes in_valid, in_data, rec_ready and pay_ready only on falling edges, and it keeps each byte on the bus until a rising edge with in_ready high has consumed it. Records are accepted only while rec_valid is high, and rec_ready is held low at other times. Payload backpressure is exercised by holding pay_ready low with a byte pending, and record backpressure by holding rec_ready low with the next opcode pending.

// File: rtl/cmdp_pkg.sv
// Shared constants and types for the command stream parser.
// Assumes byte-wide input and at most three parameter bytes per opcode.
package cmdp_pkg;
    localparam int BYTE_W    = 8;
    localparam int LEN_W     = 16;
    localparam int PARAM_MAX = 3;
    localparam int PIDX_W    = $clog2(PARAM_MAX + 1);

    typedef enum logic [1:0] {
        ST_OPCODE,
        ST_PARAM,
        ST_RECORD,
        ST_PAYLOAD
    } cmdp_state_e;

    typedef struct packed {
        logic              known;
        logic              payload;
        logic [PIDX_W-1:0] nparam;
    } cmd_info_t;
endpackage

// File: rtl/cmdp_classify.sv
// Opcode classifier: decides whether a byte is a known opcode, how many
// parameter bytes follow it, and whether a streamed payload follows the record.
// Purely combinational; assumes the opcode byte is the current input byte.
module cmdp_classify
    import cmdp_pkg::*;
(
    input  logic [BYTE_W-1:0] opcode,
    output cmd_info_t         info
);
    logic              shift_ok;
    logic              ctrl_ok;
    logic [PIDX_W-1:0] ctrl_np;
    logic [PIDX_W-1:0] shift_np;

    // Legality of a shift opcode from its write/read/mode and edge bits.
    always_comb begin
        case ({opcode[6], opcode[5], opcode[4]})
            3'b001:  shift_ok = ~opcode[2];
            3'b010:  shift_ok = ~opcode[0];
            3'b011:  shift_ok = opcode[0] ^ opcode[2];
            3'b100:  shift_ok = opcode[3] & opcode[1] & ~opcode[2];
            3'b110:  shift_ok = opcode[3] & opcode[1];
            default: shift_ok = 1'b0;
        endcase
    end

    // Parameter count of a shift opcode: length field plus optional data byte.
    always_comb begin
        if (!opcode[1])
            shift_np = PIDX_W'(2);
        else if (opcode[4] || opcode[6])
            shift_np = PIDX_W'(2);
        else
            shift_np = PIDX_W'(1);
    end

    // Legality and parameter count of a control opcode.
    always_comb begin
        ctrl_ok = 1'b0;
        if (opcode[6:5] == 2'b00) begin
            if (!opcode[4])
                ctrl_ok = 1'b1;
            else
                ctrl_ok = !opcode[3] || (opcode[2] && (opcode[1:0] != 2'b11));
        end
        case (opcode)
            8'h80, 8'h82, 8'h86, 8'h8F, 8'h91,
            8'h92, 8'h9C, 8'h9D, 8'h9E: ctrl_np = PIDX_W'(2);
            8'h8E, 8'h90:               ctrl_np = PIDX_W'(1);
            8'h93:                      ctrl_np = PIDX_W'(3);
            default:                    ctrl_np = '0;
        endcase
    end

    // Merge the two classes into one descriptor.
    always_comb begin
        info.known   = opcode[7] ? ctrl_ok : shift_ok;
        info.payload = ~opcode[7] & ~opcode[1] & opcode[4];
        info.nparam  = opcode[7] ? ctrl_np : shift_np;
    end
endmodule

// File: rtl/cmdp_collect.sv
// Command collector: sequences opcode, parameter bytes, record hand-off and
// payload pass-through. Parameter bytes are stored one register slot each.
// Assumes 'info' is the classification of the current input byte.
module cmdp_collect
    import cmdp_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid,
    input  logic [BYTE_W-1:0]             in_data,
    input  cmd_info_t                     info,
    input  logic                          rec_ready,
    input  logic                          pay_ready,
    output logic                          in_ready,
    output logic                          rec_valid,
    output logic                          pay_valid,
    output logic                          bad_cmd,
    output logic [BYTE_W-1:0]             op_q,
    output logic [PARAM_MAX*BYTE_W-1:0]   pbuf_flat
);
    cmdp_state_e       state;
    logic [PIDX_W-1:0] idx;
    logic [PIDX_W-1:0] need;
    logic              has_pay;
    logic [LEN_W-1:0]  pay_left;
    logic              take;

    // A byte moves this cycle.
    assign take = in_valid && in_ready;

    // Handshake outputs derived from the current state.
    always_comb begin
        in_ready  = 1'b0;
        rec_valid = 1'b0;
        pay_valid = 1'b0;
        case (state)
            ST_OPCODE, ST_PARAM: in_ready = 1'b1;
            ST_RECORD:           rec_valid = 1'b1;
            ST_PAYLOAD: begin
                in_ready  = pay_ready;
                pay_valid = in_valid;
            end
            default: ;
        endcase
    end

    // Sequencer: state, parameter index, payload countdown, error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_OPCODE;
            idx      <= '0;
            need     <= '0;
            has_pay  <= 1'b0;
            pay_left <= '0;
            op_q     <= '0;
            bad_cmd  <= 1'b0;
        end else begin
            bad_cmd <= 1'b0;
            case (state)
                ST_OPCODE: if (take) begin
                    if (!info.known) begin
                        bad_cmd <= 1'b1;
                    end else begin
                        op_q    <= in_data;
                        has_pay <= info.payload;
                        need    <= info.nparam;
                        idx     <= '0;
                        state   <= (info.nparam == '0) ? ST_RECORD : ST_PARAM;
                    end
                end
                ST_PARAM: if (take) begin
                    idx <= idx + PIDX_W'(1);
                    if (idx == need - PIDX_W'(1))
                        state <= ST_RECORD;
                end
                ST_RECORD: if (rec_ready) begin
                    if (has_pay) begin
                        pay_left <= LEN_W'(pbuf_flat[2*BYTE_W-1:0]);
                        state    <= ST_PAYLOAD;
                    end else begin
                        state <= ST_OPCODE;
                    end
                end
                ST_PAYLOAD: if (take) begin
                    if (pay_left == '0)
                        state <= ST_OPCODE;
                    else
                        pay_left <= pay_left - LEN_W'(1);
                end
                default: state <= ST_OPCODE;
            endcase
        end
    end

    for (genvar g = 0; g < PARAM_MAX; g++) begin : g_slot
        logic [BYTE_W-1:0] slot;
        // Parameter slot g: cleared on a new opcode, loaded on its turn.
        always_ff @(posedge clk) begin
            if (!rst_n)
                slot <= '0;
            else if (state == ST_OPCODE && take)
                slot <= '0;
            else if (state == ST_PARAM && take && idx == PIDX_W'(g))
                slot <= in_data;
        end
        assign pbuf_flat[g*BYTE_W +: BYTE_W] = slot;
    end
endmodule

// File: rtl/cmdp_fields.sv
// Record formatter: places the stored parameter bytes into the record fields
// the opcode defines. Combinational; assumes unused slots read as zero.
module cmdp_fields
    import cmdp_pkg::*;
(
    input  logic [BYTE_W-1:0]           opcode,
    input  logic [PARAM_MAX*BYTE_W-1:0] pbuf_flat,
    output logic [LEN_W-1:0]            length,
    output logic [BYTE_W-1:0]           gpio_value,
    output logic [BYTE_W-1:0]           gpio_dir,
    output logic [2*BYTE_W-1:0]         addr,
    output logic [BYTE_W-1:0]           data
);
    logic [BYTE_W-1:0] p0, p1, p2;

    assign p0 = pbuf_flat[0*BYTE_W +: BYTE_W];
    assign p1 = pbuf_flat[1*BYTE_W +: BYTE_W];
    assign p2 = pbuf_flat[2*BYTE_W +: BYTE_W];

    // Map the parameter bytes onto the record fields by opcode.
    always_comb begin
        length     = '0;
        gpio_value = '0;
        gpio_dir   = '0;
        addr       = '0;
        data       = '0;
        if (!opcode[7]) begin
            if (!opcode[1]) begin
                length = LEN_W'({p1, p0});
            end else begin
                length = LEN_W'(p0);
                data   = p1;
            end
        end else begin
            case (opcode)
                8'h80, 8'h82: begin
                    gpio_value = p0;
                    gpio_dir   = p1;
                end
                8'h86, 8'h8F, 8'h9C, 8'h9D, 8'h9E: length = LEN_W'({p1, p0});
                8'h8E: length = LEN_W'(p0);
                8'h90: addr = {{BYTE_W{1'b0}}, p0};
                8'h91: addr = {p0, p1};
                8'h92: begin
                    addr = {{BYTE_W{1'b0}}, p0};
                    data = p1;
                end
                8'h93: begin
                    addr = {p0, p1};
                    data = p2;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/cmdstream_parser.sv
// Top of the command stream parser: classifies each input opcode, collects
// its parameters, offers one record, then streams any write payload.
// Assumes the input side holds a byte until in_ready takes it.
module cmdstream_parser
    import cmdp_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [7:0]  in_data,
    output logic        in_ready,
    output logic        rec_valid,
    input  logic        rec_ready,
    output logic [7:0]  rec_opcode,
    output logic [15:0] rec_length,
    output logic [7:0]  rec_gpio_value,
    output logic [7:0]  rec_gpio_dir,
    output logic [15:0] rec_addr,
    output logic [7:0]  rec_data,
    output logic        pay_valid,
    input  logic        pay_ready,
    output logic [7:0]  pay_data,
    output logic        bad_cmd
);
    cmd_info_t                   info;
    logic [PARAM_MAX*BYTE_W-1:0] pbuf_flat;

    cmdp_classify u_classify (
        .opcode (in_data),
        .info   (info)
    );

    cmdp_collect u_collect (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .info      (info),
        .rec_ready (rec_ready),
        .pay_ready (pay_ready),
        .in_ready  (in_ready),
        .rec_valid (rec_valid),
        .pay_valid (pay_valid),
        .bad_cmd   (bad_cmd),
        .op_q      (rec_opcode),
        .pbuf_flat (pbuf_flat)
    );

    cmdp_fields u_fields (
        .opcode     (rec_opcode),
        .pbuf_flat  (pbuf_flat),
        .length     (rec_length),
        .gpio_value (rec_gpio_value),
        .gpio_dir   (rec_gpio_dir),
        .addr       (rec_addr),
        .data       (rec_data)
    );

    // Payload bytes pass straight from the input.
    assign pay_data = in_data;
endmodule

// File: rtl/cmdp_checks.sv
// Checker for the command stream parser, attached by bind. Assumes the
// consumers change their ready inputs only between clock edges.
module cmdp_checks (
    input logic        clk,
    input logic        rst_n,
    input logic        in_ready,
    input logic        rec_valid,
    input logic        rec_ready,
    input logic [7:0]  rec_opcode,
    input logic [15:0] rec_length,
    input logic [7:0]  rec_gpio_value,
    input logic [7:0]  rec_gpio_dir,
    input logic [15:0] rec_addr,
    input logic [7:0]  rec_data,
    input logic        pay_valid,
    input logic        bad_cmd
);
    // R10: a pending record blocks input
    a_r10_block_input: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid |-> !in_ready);

    // R10: a record not taken holds steady
    a_r10_record_hold: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid && !rec_ready |=> rec_valid && $stable(rec_opcode) &&
        $stable(rec_length) && $stable(rec_gpio_value) && $stable(rec_gpio_dir) &&
        $stable(rec_addr) && $stable(rec_data));

    // R9: an error flag never coincides with a record and leaves the parser open
    a_r9_bad_clean: assert property (@(posedge clk) disable iff (!rst_n)
        bad_cmd |-> !rec_valid && in_ready);

    // R4: payload and record never overlap
    a_r4_pay_excl: assert property (@(posedge clk) disable iff (!rst_n)
        pay_valid |-> !rec_valid);

    // R4: only a byte-mode write record is followed by payload
    a_r4_no_stray_pay: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid && rec_ready && !(!rec_opcode[7] && !rec_opcode[1] && rec_opcode[4])
        |=> !pay_valid);

    // R5: bit-mode length is a single byte
    a_r5_bit_len: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid && !rec_opcode[7] && rec_opcode[1] |-> rec_length[15:8] == 8'h00);

    // R2: a parameterless opcode carries all-zero fields
    a_r2_zero_fields: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid && rec_opcode == 8'h87 |-> rec_length == '0 && rec_gpio_value == '0 &&
        rec_gpio_dir == '0 && rec_addr == '0 && rec_data == '0);
endmodule

bind cmdstream_parser cmdp_checks u_checks (
    .clk            (clk),
    .rst_n          (rst_n),
    .in_ready       (in_ready),
    .rec_valid      (rec_valid),
    .rec_ready      (rec_ready),
    .rec_opcode     (rec_opcode),
    .rec_length     (rec_length),
    .rec_gpio_value (rec_gpio_value),
    .rec_gpio_dir   (rec_gpio_dir),
    .rec_addr       (rec_addr),
    .rec_data       (rec_data),
    .pay_valid      (pay_valid),
    .bad_cmd        (bad_cmd)
);

// File: tb/tb_cmdstream_parser.sv
module tb_cmdstream_parser;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = '0;
    logic        in_ready;
    logic        rec_valid;
    logic        rec_ready = 1'b0;
    logic [7:0]  rec_opcode;
    logic [15:0] rec_length;
    logic [7:0]  rec_gpio_value;
    logic [7:0]  rec_gpio_dir;
    logic [15:0] rec_addr;
    logic [7:0]  rec_data;
    logic        pay_valid;
    logic        pay_ready = 1'b0;
    logic [7:0]  pay_data;
    logic        bad_cmd;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    cmdstream_parser dut (.*);

    typedef struct packed {
        logic [1:0]  np;
        logic [7:0]  op;
        logic [7:0]  p0;
        logic [7:0]  p1;
        logic [7:0]  p2;
        logic        bad;
        logic [15:0] len;
        logic [7:0]  gv;
        logic [7:0]  gd;
        logic [15:0] addr;
        logic [7:0]  dat;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VEC [NV] = '{
        '{2'd0, 8'h87, 8'h00, 8'h00, 8'h00, 1'b0, 16'h0000, 8'h00, 8'h00, 16'h0000, 8'h00, 4'd2},  // R2
        '{2'd0, 8'h8C, 8'h00, 8'h00, 8'h00, 1'b0, 16'h0000, 8'h00, 8'h00, 16'h0000, 8'h00, 4'd2},  // R2
        '{2'd0, 8'h95, 8'h00, 8'h00, 8'h00, 1'b0, 16'h0000, 8'h00, 8'h00, 16'h0000, 8'h00, 4'd2},  // R2
        '{2'd2, 8'h20, 8'h34, 8'h12, 8'h00, 1'b0, 16'h1234, 8'h00, 8'h00, 16'h0000, 8'h00, 4'd3},  // R3
        '{2'd1, 8'h22, 8'h05, 8'h00, 8'h00, 1'b0, 16'h0005, 8'h00, 8'h00, 16'h0000, 8'h00, 4'd5},  // R5
        '{2'd2, 8'h13, 8'h06, 8'hA5, 8'h00, 1'b0, 16'h0006, 8'h00, 8'h00, 16'h0000, 8'hA5, 4'd5},  // R5
        '{2'd2, 8'h4B, 8'h02, 8'h03, 8'h00, 1'b0, 16'h0002, 8'h00, 8'h00, 16'h0000, 8'h03, 4'd5},  // R5
        '{2'd2, 8'h6F, 8'h01, 8'h80, 8'h00, 1'b0, 16'h0001, 8'h00, 8'h00, 16'h0000, 8'h80, 4'd5},  // R5
        '{2'd2, 8'h80, 8'h55, 8'hF0, 8'h00, 1'b0, 16'h0000, 8'h55, 8'hF0, 16'h0000, 8'h00, 4'd6},  // R6
        '{2'd2, 8'h82, 8'hAA, 8'h0F, 8'h00, 1'b0, 16'h0000, 8'hAA, 8'h0F, 16'h0000, 8'h00, 4'd6},  // R6
        '{2'd1, 8'h90, 8'h3C, 8'h00, 8'h00, 1'b0, 16'h0000, 8'h00, 8'h00, 16'h003C, 8'h00, 4'd7},  // R7
        '{2'd2, 8'h91, 8'h12, 8'h34, 8'h00, 1'b0, 16'h0000, 8'h00, 8'h00, 16'h1234, 8'h00, 4'd7},  // R7
        '{2'd2, 8'h92, 8'h77, 8'h99, 8'h00, 1'b0, 16'h0000, 8'h00, 8'h00, 16'h0077, 8'h99, 4'd7},  // R7
        '{2'd3, 8'h93, 8'hAB, 8'hCD, 8'hEF, 1'b0, 16'h0000, 8'h00, 8'h00, 16'hABCD, 8'hEF, 4'd7},  // R7
        '{2'd2, 8'h86, 8'h05, 8'h01, 8'h00, 1'b0, 16'h0105, 8'h00, 8'h00, 16'h0000, 8'h00, 4'd8},  // R8
        '{2'd1, 8'h8E, 8'h07, 8'h00, 8'h00, 1'b0, 16'h0007, 8'h00, 8'h00, 16'h0000, 8'h00, 4'd8},  // R8
        '{2'd2, 8'h9E, 8'h11, 8'h22, 8'h00, 1'b0, 16'h2211, 8'h00, 8'h00, 16'h0000, 8'h00, 4'd8},  // R8
        '{2'd0, 8'h98, 8'h00, 8'h00, 8'h00, 1'b1, 16'h0000, 8'h00, 8'h00, 16'h0000, 8'h00, 4'd9},  // R9
        '{2'd0, 8'h00, 8'h00, 8'h00, 8'h00, 1'b1, 16'h0000, 8'h00, 8'h00, 16'h0000, 8'h00, 4'd9},  // R9
        '{2'd0, 8'h4C, 8'h00, 8'h00, 8'h00, 1'b1, 16'h0000, 8'h00, 8'h00, 16'h0000, 8'h00, 4'd9},  // R9
        '{2'd0, 8'h9F, 8'h00, 8'h00, 8'h00, 1'b1, 16'h0000, 8'h00, 8'h00, 16'h0000, 8'h00, 4'd9},  // R9
        '{2'd0, 8'hFF, 8'h00, 8'h00, 8'h00, 1'b1, 16'h0000, 8'h00, 8'h00, 16'h0000, 8'h00, 4'd9}   // R9
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    // Offer one byte and return at the falling edge after it was taken.
    task automatic send(input logic [7:0] b);
        in_valid = 1'b1;
        in_data  = b;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Offer one payload byte, checking it appears on the payload port.
    task automatic send_pay(input logic [7:0] b, input string tag);
        in_valid = 1'b1;
        in_data  = b;
        #1;
        chk({tag, " pay_valid"}, pay_valid, 1);
        chk({tag, " pay_data"}, pay_data, b);
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic accept();
        rec_ready = 1'b1;
        @(negedge clk);
        rec_ready = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1 in_ready", in_ready, 1);
        chk("R1 rec_valid", rec_valid, 0);
        chk("R1 pay_valid", pay_valid, 0);
        chk("R1 bad_cmd", bad_cmd, 0);

        // Table walk over opcode classes
        for (int k = 0; k < NV; k++) begin
            string t;
            t = $sformatf("R%0d vec%0d op%0h", VEC[k].req, k, VEC[k].op);
            send(VEC[k].op);
            if (VEC[k].np >= 2'd1) send(VEC[k].p0);
            if (VEC[k].np >= 2'd2) send(VEC[k].p1);
            if (VEC[k].np >= 2'd3) send(VEC[k].p2);
            if (VEC[k].bad) begin
                chk({t, " bad_cmd"}, bad_cmd, 1);
                chk({t, " rec_valid"}, rec_valid, 0);
                @(negedge clk);
                chk({t, " bad_cmd one cycle"}, bad_cmd, 0);
            end else begin
                chk({t, " rec_valid"}, rec_valid, 1);
                chk({t, " opcode"}, rec_opcode, VEC[k].op);
                chk({t, " length"}, rec_length, VEC[k].len);
                chk({t, " gpio_value"}, rec_gpio_value, VEC[k].gv);
                chk({t, " gpio_dir"}, rec_gpio_dir, VEC[k].gd);
                chk({t, " addr"}, rec_addr, VEC[k].addr);
                chk({t, " data"}, rec_data, VEC[k].dat);
                accept();
                chk({t, " released"}, rec_valid, 0);
                chk({t, " no payload"}, pay_valid, 0);
            end
        end

        // R3 R4: byte-mode write with length 2 streams three bytes
        pay_ready = 1'b1;
        send(8'h19); send(8'h02); send(8'h00);
        chk("R3 write rec_valid", rec_valid, 1);
        chk("R3 write length", rec_length, 16'h0002);
        accept();
        for (int i = 0; i < 3; i++) send_pay(8'hC0 + 8'(i), "R4 payload");
        pay_ready = 1'b0;
        chk("R4 back to opcode in_ready", in_ready, 1);
        send(8'h87);
        chk("R4 resync rec_valid", rec_valid, 1);
        chk("R4 resync opcode", rec_opcode, 8'h87);
        accept();

        // R4 R11: zero length gives one payload byte; backpressure holds it
        send(8'h10); send(8'h00); send(8'h00);
        chk("R4 zero length", rec_length, 16'h0000);
        accept();
        in_valid = 1'b1;
        in_data  = 8'h5A;
        repeat (2) @(negedge clk);
        chk("R11 stalled in_ready", in_ready, 0);
        chk("R11 stalled pay_valid", pay_valid, 1);
        chk("R11 stalled pay_data", pay_data, 8'h5A);
        pay_ready = 1'b1;
        @(negedge clk);
        in_valid  = 1'b0;
        pay_ready = 1'b0;
        chk("R4 single byte then opcode", in_ready, 1);
        send(8'h85);
        chk("R4 opcode after single byte", rec_opcode, 8'h85);
        accept();

        // R10: record held while the next opcode waits
        send(8'h80); send(8'h55); send(8'hF0);
        in_valid = 1'b1;
        in_data  = 8'h87;
        repeat (3) @(negedge clk);
        chk("R10 in_ready low", in_ready, 0);
        chk("R10 rec_valid held", rec_valid, 1);
        chk("R10 gpio_value held", rec_gpio_value, 8'h55);
        chk("R10 gpio_dir held", rec_gpio_dir, 8'hF0);
        rec_ready = 1'b1;
        @(negedge clk);
        rec_ready = 1'b0;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R10 pending opcode taken", rec_opcode, 8'h87);
        chk("R10 pending rec_valid", rec_valid, 1);
        accept();

        // R9: bad opcode then an immediate valid one
        send(8'hA5);
        chk("R9 bad pulse", bad_cmd, 1);
        send(8'h8A);
        chk("R9 pulse ended", bad_cmd, 0);
        chk("R9 next opcode", rec_opcode, 8'h8A);
        chk("R9 next rec_valid", rec_valid, 1);
        accept();

        // R12: reset mid-command discards it
        send(8'h93); send(8'h01);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R12 rec_valid after reset", rec_valid, 0);
        chk("R12 in_ready after reset", in_ready, 1);
        send(8'h84);
        chk("R12 fresh opcode rec_valid", rec_valid, 1);
        chk("R12 fresh opcode", rec_opcode, 8'h84);
        chk("R12 fresh addr", rec_addr, 16'h0000);
        accept();

        summary();
        $finish;
    end
endmodule